// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block arbitrates a set of level-sensitive interrupt request lines, each with its own programmable priority, and presents the number of the most urgent pending, unblocked line as a vector word on a small synchronous register bus. When no request qualifies, the vector word reads as all ones. A set-and-enable lock register can block every request whose priority sits at or below a chosen threshold. Reading a second vector address returns the same word and, as a side effect of the read, acknowledges the reported line. An acknowledged line is kept out of arbitration until it goes low and is raised again.

Two steering registers can each pick one request line and route it to the two top slots of a small companion fast-interrupt encoder. The encoder's remaining slots come straight from external fast-request pins. It reports its own short code. While a line is steered, it takes no part in normal arbitration.

The bus is a single-cycle word-addressed port. Reads are combinational from the address, and writes are committed on the clock edge. Word addresses: 0 vector, 1 acknowledge-vector, 2 fast vector, 3 lock, 4 fast slot 6 steering, 5 fast slot 7 steering, and 16 + n for the priority of line n.

Top module: `vpic_top`

## Requirements
- R1: After reset, the vector, acknowledge-vector and fast vector addresses read 0xFFFF_FFFF, the lock register reads 0, both steering registers read 0x0000_000F, and every priority register reads 0.
- R2: The vector address reads the number of the pending, unblocked line with the largest priority value in bits 3:0, with bits 31:4 zero, and irq_o is high.
- R3: When several qualifying lines share the largest priority value, the lowest line number is reported.
- R4: When no line qualifies, the vector address reads 0xFFFF_FFFF and irq_o is low.
- R5: With lock bit 7 set, any line whose priority is less than or equal to lock bits 3:0 is blocked. With bit 7 clear, the lock has no effect. The register reads back as written in bits 7 and 3:0.
- R6: A read of the acknowledge-vector address returns the same word as the vector address. The line it reports is then excluded from arbitration until its request has been seen low on a clock edge and is raised again.
- R7: A read of the vector address changes no state. Writes to the three vector addresses are ignored.
- R8: A steering register with bit 7 set drives fast slot 6 (address 4) or fast slot 7 (address 5) from the request line numbered in its bits 3:0. The register reads back as written in bits 7 and 3:0.
- R9: A line named by an enabled steering register takes no part in normal vector arbitration.
- R10: The fast vector address reads the highest-numbered pending fast slot in bits 2:0, with bits 31:3 zero, and fiq_o is high. It reads 0xFFFF_FFFF with fiq_o low when no fast slot is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 16 | Level interrupt request lines |
| fiq_ext_i | input | 6 | External fast-request lines for fast slots 0 to 5 |
| bus_addr_i | input | 5 | Word address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe (needed for the acknowledge side effect) |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| irq_o | output | 1 | A normal request qualifies |
| fiq_o | output | 1 | A fast slot is pending |

## Verification
The assertions take for granted that request lines and bus signals are synchronous to the clock and hold steady across each rising edge. They also assume a read strobe never coincides with a write strobe, so an acknowledge is never mixed with a register update. The stimulus changes every input only at the falling edge. It drives one bus access at a time and clears the strobe just after the edge that commits it. Before each arbitration check, it lowers all request lines for at least one edge, so no acknowledge block carries over from an earlier scenario.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
   // word addresses of the control space (priority space sits above it)
   localparam int ADR_VEC  = 0;
   localparam int ADR_ACK  = 1;
   localparam int ADR_FVEC = 2;
   localparam int ADR_LOCK = 3;
   localparam int ADR_SEL6 = 4;
   localparam int ADR_SEL7 = 5;
   localparam int CTRL_REGS = 6;
   // enable flag position in lock and steering registers
   localparam int EN_BIT = 7;
   // number of steering registers feeding the fast encoder
   localparam int NUM_STEER = 2;
endpackage

// File: rtl/vpic_prio_arbiter.sv
module vpic_prio_arbiter #(
   parameter int N      = 16,
   parameter int PRIO_W = 4,
   parameter int IDX_W  = 4
) (
   input  logic [N-1:0]             req_i,
   input  logic [N-1:0][PRIO_W-1:0] prio_i,
   output logic                     valid_o,
   output logic [IDX_W-1:0]         idx_o
);
   logic [PRIO_W-1:0] best_prio;

   // strict greater-than keeps the lowest index on a tie
   always_comb begin
      valid_o   = 1'b0;
      idx_o     = '0;
      best_prio = '0;
      for (int i = 0; i < N; i++) begin
         if (req_i[i] && (!valid_o || prio_i[i] > best_prio)) begin
            valid_o   = 1'b1;
            idx_o     = IDX_W'(i);
            best_prio = prio_i[i];
         end
      end
   end
endmodule

// File: rtl/vpic_ack_tracker.sv
module vpic_ack_tracker #(
   parameter int N     = 16,
   parameter int IDX_W = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [N-1:0]     irq_i,
   input  logic             ack_i,
   input  logic [IDX_W-1:0] ack_idx_i,
   output logic [N-1:0]     hold_o
);
   for (genvar g = 0; g < N; g++) begin : g_line
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)
            hold_o[g] <= 1'b0;
         else if (!irq_i[g])
            hold_o[g] <= 1'b0;
         else if (ack_i && ack_idx_i == IDX_W'(g))
            hold_o[g] <= 1'b1;
      end
   end
endmodule

// File: rtl/vpic_fast_encoder.sv
module vpic_fast_encoder #(
   parameter int N         = 8,
   parameter bit HIGH_WINS = 1'b1,
   localparam int CODE_W   = $clog2(N)
) (
   input  logic [N-1:0]      req_i,
   output logic              valid_o,
   output logic [CODE_W-1:0] code_o
);
   if (HIGH_WINS) begin : g_high
      always_comb begin
         valid_o = 1'b0;
         code_o  = '0;
         for (int i = 0; i < N; i++)
            if (req_i[i]) begin
               valid_o = 1'b1;
               code_o  = CODE_W'(i);
            end
      end
   end else begin : g_low
      always_comb begin
         valid_o = 1'b0;
         code_o  = '0;
         for (int i = N - 1; i >= 0; i--)
            if (req_i[i]) begin
               valid_o = 1'b1;
               code_o  = CODE_W'(i);
            end
      end
   end
endmodule

// File: rtl/vpic_top.sv
module vpic_top
   import vpic_pkg::*;
#(
   parameter int NUM_IRQ   = 16,
   parameter int PRIO_W    = 4,
   parameter int NUM_FIQ   = 8,
   parameter int DATA_W    = 32,
   parameter bit FIQ_HIGH_WINS = 1'b1,
   localparam int IDX_W    = $clog2(NUM_IRQ),
   localparam int ADDR_W   = IDX_W + 1,
   localparam int FCODE_W  = $clog2(NUM_FIQ),
   localparam int NUM_FEXT = NUM_FIQ - NUM_STEER
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [NUM_IRQ-1:0]  irq_i,
   input  logic [NUM_FEXT-1:0] fiq_ext_i,
   input  logic [ADDR_W-1:0]   bus_addr_i,
   input  logic                bus_wr_i,
   input  logic                bus_rd_i,
   input  logic [DATA_W-1:0]   bus_wdata_i,
   output logic [DATA_W-1:0]   bus_rdata_o,
   output logic                irq_o,
   output logic                fiq_o
);
   // elaboration-time parameter checks
   if (IDX_W < 3 || (1 << IDX_W) < CTRL_REGS) begin : g_bad_irq
      $error("NUM_IRQ too small for the control address space");
   end
   if (PRIO_W > EN_BIT || IDX_W > EN_BIT) begin : g_bad_width
      $error("fields must fit below the enable bit");
   end
   if (DATA_W <= EN_BIT || NUM_FIQ <= NUM_STEER) begin : g_bad_misc
      $error("DATA_W or NUM_FIQ out of range");
   end

   logic [NUM_IRQ-1:0][PRIO_W-1:0]   prio_q;
   logic                             lock_en_q;
   logic [PRIO_W-1:0]                lock_prio_q;
   logic [NUM_STEER-1:0]             sel_en_q;
   logic [NUM_STEER-1:0][IDX_W-1:0]  sel_idx_q;

   logic [NUM_IRQ-1:0] hold, redir, locked, cand;
   logic               irq_valid, ack_fire;
   logic [IDX_W-1:0]   win_idx;
   logic [NUM_FIQ-1:0] fiq_req;
   logic               fiq_valid;
   logic [FCODE_W-1:0] fiq_code;

   wire               in_prio_space = bus_addr_i[ADDR_W-1];
   wire [IDX_W-1:0]   loc_idx       = bus_addr_i[IDX_W-1:0];
   wire               loc_ok        = int'(loc_idx) < NUM_IRQ;

   // steering: redirect mask and fast slots at the top of the encoder
   always_comb begin
      redir = '0;
      for (int s = 0; s < NUM_STEER; s++)
         if (sel_en_q[s] && int'(sel_idx_q[s]) < NUM_IRQ)
            redir[sel_idx_q[s]] = 1'b1;
   end

   for (genvar s = 0; s < NUM_STEER; s++) begin : g_steer
      assign fiq_req[NUM_FEXT+s] = sel_en_q[s] && int'(sel_idx_q[s]) < NUM_IRQ
                                   && irq_i[sel_idx_q[s]];
   end
   assign fiq_req[NUM_FEXT-1:0] = fiq_ext_i;

   for (genvar g = 0; g < NUM_IRQ; g++) begin : g_cand
      assign locked[g] = lock_en_q && (prio_q[g] <= lock_prio_q);
   end
   assign cand = irq_i & ~hold & ~redir & ~locked;

   vpic_prio_arbiter #(.N(NUM_IRQ), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) i_arb (
      .req_i   (cand),
      .prio_i  (prio_q),
      .valid_o (irq_valid),
      .idx_o   (win_idx)
   );

   assign ack_fire = bus_rd_i && !bus_wr_i && !in_prio_space
                     && loc_idx == IDX_W'(ADR_ACK) && irq_valid;

   vpic_ack_tracker #(.N(NUM_IRQ), .IDX_W(IDX_W)) i_ack (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .irq_i     (irq_i),
      .ack_i     (ack_fire),
      .ack_idx_i (win_idx),
      .hold_o    (hold)
   );

   vpic_fast_encoder #(.N(NUM_FIQ), .HIGH_WINS(FIQ_HIGH_WINS)) i_fenc (
      .req_i   (fiq_req),
      .valid_o (fiq_valid),
      .code_o  (fiq_code)
   );

   // register writes
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prio_q      <= '0;
         lock_en_q   <= 1'b0;
         lock_prio_q <= '0;
         sel_en_q    <= '0;
         sel_idx_q   <= '1;
      end else if (bus_wr_i) begin
         if (in_prio_space) begin
            if (loc_ok) prio_q[loc_idx] <= bus_wdata_i[PRIO_W-1:0];
         end else begin
            case (int'(loc_idx))
               ADR_LOCK: begin
                  lock_en_q   <= bus_wdata_i[EN_BIT];
                  lock_prio_q <= bus_wdata_i[PRIO_W-1:0];
               end
               ADR_SEL6, ADR_SEL7: begin
                  sel_en_q[int'(loc_idx) - ADR_SEL6]  <= bus_wdata_i[EN_BIT];
                  sel_idx_q[int'(loc_idx) - ADR_SEL6] <= bus_wdata_i[IDX_W-1:0];
               end
               default: ;
            endcase
         end
      end
   end

   // combinational read mux
   always_comb begin
      bus_rdata_o = '0;
      if (in_prio_space) begin
         if (loc_ok) bus_rdata_o[PRIO_W-1:0] = prio_q[loc_idx];
      end else begin
         case (int'(loc_idx))
            ADR_VEC, ADR_ACK:
               bus_rdata_o = irq_valid ? DATA_W'(win_idx) : '1;
            ADR_FVEC:
               bus_rdata_o = fiq_valid ? DATA_W'(fiq_code) : '1;
            ADR_LOCK: begin
               bus_rdata_o[EN_BIT]     = lock_en_q;
               bus_rdata_o[PRIO_W-1:0] = lock_prio_q;
            end
            ADR_SEL6, ADR_SEL7: begin
               bus_rdata_o[EN_BIT]    = sel_en_q[int'(loc_idx) - ADR_SEL6];
               bus_rdata_o[IDX_W-1:0] = sel_idx_q[int'(loc_idx) - ADR_SEL6];
            end
            default: ;
         endcase
      end
   end

   assign irq_o = irq_valid;
   assign fiq_o = fiq_valid;

   // ---------------- assertions ----------------
   p_winner_pending_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_valid |-> irq_i[win_idx]);

   p_idle_no_irq_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_i == '0) |-> !irq_o);

   p_lock_blocks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_valid && lock_en_q) |-> (prio_q[win_idx] > lock_prio_q));

   p_ack_removes_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_fire |=> !(irq_valid && win_idx == $past(win_idx)));

   p_ro_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_wr_i && !in_prio_space && int'(loc_idx) < ADR_LOCK)
      |=> ($stable(lock_en_q) && $stable(lock_prio_q) && $stable(sel_en_q)
           && $stable(sel_idx_q) && $stable(prio_q)));

   p_steered_out_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_valid |-> !redir[win_idx]);

   p_fast_pending_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fiq_o |-> fiq_req[fiq_code]);
endmodule

// File: tb/test_vpic_top.sv
`timescale 1ns/1ps
module test_vpic_top;
   localparam logic [31:0] DEF = 32'hFFFF_FFFF;
   localparam logic [4:0] A_VEC = 5'd0, A_ACK = 5'd1, A_FVEC = 5'd2,
                          A_LOCK = 5'd3, A_SEL6 = 5'd4, A_SEL7 = 5'd5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] irq = '0;
   logic [5:0]  fext = '0;
   logic [4:0]  addr = '0;
   logic        wr = 1'b0, rd = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq_o, fiq_o;
   int          n_run = 0, n_fail = 0;

   always #2.5 clk = ~clk;

   vpic_top i_vpic_top (
      .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .fiq_ext_i(fext),
      .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd), .bus_wdata_i(wdata),
      .bus_rdata_o(rdata), .irq_o(irq_o), .fiq_o(fiq_o));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      @(posedge clk);
      #1 wr = 1'b0;
   endtask

   task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a; rd = 1'b1;
      #1 d = rdata;
      @(posedge clk);
      #1 rd = 1'b0;
   endtask

   task automatic set_irq(input logic [15:0] v);
      @(negedge clk);
      irq = v;
   endtask

   task automatic expect_reg(input string req, input logic [4:0] a, input logic [31:0] exp);
      logic [31:0] d;
      bus_read(a, d);
      check(req, d, exp);
   endtask

   task automatic t_reset;
      expect_reg("R1 vector", A_VEC, DEF);
      expect_reg("R1 ack vector", A_ACK, DEF);
      expect_reg("R1 fast vector", A_FVEC, DEF);
      expect_reg("R1 lock", A_LOCK, 32'h0);
      expect_reg("R1 sel6", A_SEL6, 32'h0000_000F);
      expect_reg("R1 sel7", A_SEL7, 32'h0000_000F);
      expect_reg("R1 prio3", 5'd19, 32'h0);
      check("R4 irq_o idle", {31'b0, irq_o}, 32'h0);
   endtask

   task automatic t_priority;
      bus_write(5'd18, 32'd5);    // line 2
      bus_write(5'd25, 32'd12);   // line 9
      bus_write(5'd30, 32'd7);    // line 14
      expect_reg("R2 prio9 readback", 5'd25, 32'd12);
      set_irq(16'h4204);
      expect_reg("R2 highest of 2,9,14", A_VEC, 32'd9);
      check("R2 irq_o", {31'b0, irq_o}, 32'h1);
      set_irq(16'h4004);
      expect_reg("R2 highest of 2,14", A_VEC, 32'd14);
      set_irq(16'h0);
      expect_reg("R4 none pending", A_VEC, DEF);
   endtask

   task automatic t_tie;
      set_irq(16'h0808);           // lines 3 and 11, both priority 0
      expect_reg("R3 tie lower wins", A_VEC, 32'd3);
      set_irq(16'h0);
   endtask

   task automatic t_lock;
      bus_write(A_LOCK, 32'h87);
      expect_reg("R5 lock readback", A_LOCK, 32'h87);
      set_irq(16'h4004);           // prio 5 and 7 (equal to lock)
      expect_reg("R5 at-or-below blocked", A_VEC, DEF);
      check("R5 irq_o low", {31'b0, irq_o}, 32'h0);
      set_irq(16'h4204);
      expect_reg("R5 above lock passes", A_VEC, 32'd9);
      bus_write(A_LOCK, 32'h07);
      set_irq(16'h4004);
      expect_reg("R5 lock disabled", A_VEC, 32'd14);
      bus_write(A_LOCK, 32'h0);
      set_irq(16'h0);
   endtask

   task automatic t_ack;
      set_irq(16'h4200);           // lines 9 (prio 12) and 14 (prio 7)
      expect_reg("R6 ack returns vector", A_ACK, 32'd9);
      expect_reg("R6 acked line removed", A_VEC, 32'd14);
      expect_reg("R7 plain read no effect", A_VEC, 32'd14);
      expect_reg("R7 plain read repeat", A_VEC, 32'd14);
      expect_reg("R6 still held while high", A_VEC, 32'd14);
      set_irq(16'h4000);
      set_irq(16'h4200);
      expect_reg("R6 re-raised line returns", A_VEC, 32'd9);
      set_irq(16'h0);
      expect_reg("R6 ack with nothing pending", A_ACK, DEF);
   endtask

   task automatic t_readonly;
      bus_write(A_LOCK, 32'h83);
      set_irq(16'h0200);
      bus_write(A_VEC, 32'h0000_0000);
      bus_write(A_ACK, 32'h0000_0000);
      bus_write(A_FVEC, 32'h0000_0000);
      expect_reg("R7 lock untouched", A_LOCK, 32'h83);
      expect_reg("R7 write to ack address no ack", A_VEC, 32'd9);
      expect_reg("R7 sel6 untouched", A_SEL6, 32'h0000_000F);
      bus_write(A_LOCK, 32'h0);
      set_irq(16'h0);
   endtask

   task automatic t_fast;
      fext = 6'b01_0010;           // ext slots 1 and 4
      expect_reg("R10 highest ext slot", A_FVEC, 32'd4);
      check("R10 fiq_o", {31'b0, fiq_o}, 32'h1);
      bus_write(5'd21, 32'd15);    // line 5 top priority
      set_irq(16'h0024);           // lines 2 and 5
      expect_reg("R2 line 5 wins before steering", A_VEC, 32'd5);
      bus_write(A_SEL6, 32'h85);
      expect_reg("R8 sel6 readback", A_SEL6, 32'h85);
      expect_reg("R8 line 5 on slot 6", A_FVEC, 32'd6);
      expect_reg("R9 steered line excluded", A_VEC, 32'd2);
      bus_write(A_SEL7, 32'h82);
      expect_reg("R8 line 2 on slot 7", A_FVEC, 32'd7);
      expect_reg("R9 both steered, none left", A_VEC, DEF);
      bus_write(A_SEL6, 32'h05);
      expect_reg("R9 steering disabled returns line", A_VEC, 32'd5);
      fext = '0;
      set_irq(16'h0004);
      expect_reg("R8 slot 7 follows line 2", A_FVEC, 32'd7);
      set_irq(16'h0);
      expect_reg("R10 nothing pending", A_FVEC, DEF);
      check("R10 fiq_o low", {31'b0, fiq_o}, 32'h0);
   endtask

   initial begin : watchdog
      #(200000 * 5);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      t_reset();
      t_priority();
      t_tie();
      t_lock();
      t_ack();
      t_readonly();
      t_fast();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule